// File: doc/BRIEF.md
# Interlock Aggregator with Per-Source Trip Records

This block merges eighteen fault sources into a single latched trip. Nine are RF channels: each compares the magnitude of its signed digitized IF sample against its own programmable threshold. Eight are baseband window-comparator fault bits. The last is one external permit line, which is active high. A low level on the permit line is a fault, so a disconnected or damaged cable stops operation.

Every source has a sticky latch. On its first fault after a clear, the latch stores a snapshot of a free-running timestamp counter and the value the source showed at that moment. A host can later order the events against each other from these records. The latched trip forces the output DAC sample stream to zero and drops the interlock output level. A host clear pulse empties all latches, but only when no source is faulting at that time. The block also reports which source tripped first.

Top module: `ilk_aggregator`

## Requirements
- R1: An RF channel faults when the unsigned magnitude of its two's-complement sample is strictly greater than its unsigned threshold; the magnitude of the most negative sample is 2^(SAMP_W-1).
- R2: Source indices are fixed: RF channels 0..8, baseband bits 9..16 (bit j is source 9+j), and the external permit line is source 17. A baseband bit at 1 is a fault, and the permit line at 0 is a fault.
- R3: A fault present at a rising clock edge sets that source's bit in `latched` at that edge. `trip` is the OR of `latched`, so it is high from that edge until a clear takes effect.
- R4: While `trip` is high, `dac_out` is zero. Otherwise `dac_out` equals `dac_in`. `ilk_out` is always the inverse of `trip`.
- R5: A source's record holds a time and a value. The time is the timestamp counter value at the capturing edge. The value is the sample magnitude for RF sources, 1 for baseband sources, and 0 for the permit line. The record is read through `rec_sel`.
- R6: Only the first fault of a source after a clear is recorded. Later or continuing faults leave that source's time and value unchanged.
- R7: A `host_clear` sampled at an edge clears all latches, records and the first-source state only if no source is faulting at that edge. Otherwise it has no effect.
- R8: The timestamp counter is 0 after reset and increases by one per clock. Two records therefore differ by the number of clocks between their capturing edges.
- R9: `first_src` gives the index of the earliest latched source. When several sources latch at the same edge, the lowest index wins. `rec_ready` is high whenever any latch is set.
- R10: After reset, with the permit line high and no other fault, `latched` is 0, `trip` and `rec_ready` are low, and `ilk_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_sample | input | N_RF*SAMP_W | Signed IF samples, channel i at bits [i*SAMP_W +: SAMP_W] |
| rf_thresh | input | N_RF*SAMP_W | Unsigned magnitude thresholds, same packing |
| bb_fault | input | N_BB | Baseband fault bits, 1 = fault |
| ext_ok | input | 1 | External permit, 1 = operation allowed |
| host_clear | input | 1 | Clear request for all latches |
| dac_in | input | DAC_W | Drive samples toward the DAC |
| rec_sel | input | clog2(N_SRC) | Source whose record is shown |
| dac_out | output | DAC_W | Drive samples, zeroed while tripped |
| trip | output | 1 | Latched trip |
| ilk_out | output | 1 | Interlock output level, 1 = enabled |
| rec_ready | output | 1 | At least one record is latched |
| latched | output | N_SRC | Per-source latch bits |
| first_src | output | clog2(N_SRC) | Index of the earliest latched source |
| rec_time | output | TS_W | Timestamp of the selected record |
| rec_value | output | SAMP_W | Captured value of the selected record |

## Verification
The bench sweeps every 8-bit sample against thresholds of 0, 50, 127 and 255. This exposes a design that uses >= instead of >, or that takes the magnitude of -128 wrongly and misses the fault. It holds a fault on while issuing a clear, which exposes a design that clears while a fault is still live and would re-enable drive into a fault. It keeps a source faulting with a growing value, which exposes a design that overwrites the first record. It also checks the time difference between two staggered faults and the winner of a same-edge tie, which a design that does not snapshot the counter or picks the highest index would get wrong.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [1:0] {KIND_RF, KIND_BB, KIND_EXT} src_kind_e;

  function automatic src_kind_e kind_of(input int idx, input int n_rf, input int n_bb);
    if (idx < n_rf) return KIND_RF;
    if (idx < n_rf + n_bb) return KIND_BB;
    return KIND_EXT;
  endfunction
endpackage

// File: rtl/ilk_rf_detect.sv
module ilk_rf_detect #(
  parameter int SAMP_W = 16
) (
  input  logic [SAMP_W-1:0] sample,
  input  logic [SAMP_W-1:0] thresh,
  output logic [SAMP_W-1:0] mag,
  output logic              over
);
  // two's-complement magnitude; the most negative code maps to 2^(SAMP_W-1)
  function automatic logic [SAMP_W-1:0] mag_of(input logic [SAMP_W-1:0] s);
    return s[SAMP_W-1] ? (~s + 1'b1) : s;
  endfunction

  always_comb begin
    mag  = mag_of(sample);
    over = (mag > thresh);
  end
endmodule

// File: rtl/ilk_src_latch.sv
module ilk_src_latch #(
  parameter int TS_W  = 32,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault,
  input  logic             clear_go,
  input  logic [TS_W-1:0]  ts_now,
  input  logic [VAL_W-1:0] value,
  output logic             latched,
  output logic             first_evt,
  output logic [TS_W-1:0]  rec_time,
  output logic [VAL_W-1:0] rec_value
);
  assign first_evt = fault && !latched;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_go) begin
      latched   <= 1'b0;
      rec_time  <= '0;
      rec_value <= '0;
    end else if (first_evt) begin
      latched   <= 1'b1;
      rec_time  <= ts_now;
      rec_value <= value;
    end
  end
endmodule

// File: rtl/ilk_first_tracker.sv
module ilk_first_tracker #(
  parameter int N_SRC = 18,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_go,
  input  logic [N_SRC-1:0] first_evt,
  output logic             seen,
  output logic [SEL_W-1:0] first_src
);
  function automatic logic [SEL_W-1:0] lowest_set(input logic [N_SRC-1:0] v);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) r = SEL_W'(i);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear_go) begin
      seen      <= 1'b0;
      first_src <= '0;
    end else if (!seen && (|first_evt)) begin
      seen      <= 1'b1;
      first_src <= lowest_set(first_evt);
    end
  end
endmodule

// File: rtl/ilk_aggregator.sv
module ilk_aggregator #(
  parameter int N_RF   = 9,
  parameter int N_BB   = 8,
  parameter int SAMP_W = 16,
  parameter int TS_W   = 32,
  parameter int DAC_W  = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_RF*SAMP_W-1:0]        rf_sample,
  input  logic [N_RF*SAMP_W-1:0]        rf_thresh,
  input  logic [N_BB-1:0]               bb_fault,
  input  logic                          ext_ok,
  input  logic                          host_clear,
  input  logic [DAC_W-1:0]              dac_in,
  input  logic [$clog2(N_RF+N_BB+1)-1:0] rec_sel,
  output logic [DAC_W-1:0]              dac_out,
  output logic                          trip,
  output logic                          ilk_out,
  output logic                          rec_ready,
  output logic [N_RF+N_BB:0]            latched,
  output logic [$clog2(N_RF+N_BB+1)-1:0] first_src,
  output logic [TS_W-1:0]               rec_time,
  output logic [SAMP_W-1:0]             rec_value
);
  import ilk_pkg::*;

  localparam int N_SRC = N_RF + N_BB + 1;
  localparam int SEL_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  src_fault;
  logic [N_SRC-1:0]  first_evt;
  logic [SAMP_W-1:0] src_val   [N_SRC];
  logic [TS_W-1:0]   rec_time_a  [N_SRC];
  logic [SAMP_W-1:0] rec_value_a [N_SRC];
  logic [TS_W-1:0]   ts_now;
  logic              any_live;
  logic              clear_go;
  logic              first_seen;

  // free-running timebase
  always_ff @(posedge clk) begin
    if (!rst_n) ts_now <= '0;
    else        ts_now <= ts_now + 1'b1;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (kind_of(i, N_RF, N_BB) == KIND_RF) begin : g_rf
      ilk_rf_detect #(.SAMP_W(SAMP_W)) det_i (
        .sample(rf_sample[i*SAMP_W +: SAMP_W]),
        .thresh(rf_thresh[i*SAMP_W +: SAMP_W]),
        .mag   (src_val[i]),
        .over  (src_fault[i])
      );
    end else if (kind_of(i, N_RF, N_BB) == KIND_BB) begin : g_bb
      assign src_fault[i] = bb_fault[i-N_RF];
      assign src_val[i]   = SAMP_W'(1);
    end else begin : g_ext
      assign src_fault[i] = ~ext_ok;
      assign src_val[i]   = '0;
    end

    ilk_src_latch #(.TS_W(TS_W), .VAL_W(SAMP_W)) lat_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault    (src_fault[i]),
      .clear_go (clear_go),
      .ts_now   (ts_now),
      .value    (src_val[i]),
      .latched  (latched[i]),
      .first_evt(first_evt[i]),
      .rec_time (rec_time_a[i]),
      .rec_value(rec_value_a[i])
    );
  end

  assign any_live = |src_fault;
  assign clear_go = host_clear && !any_live;

  ilk_first_tracker #(.N_SRC(N_SRC)) first_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_go (clear_go),
    .first_evt(first_evt),
    .seen     (first_seen),
    .first_src(first_src)
  );

  assign trip      = |latched;
  assign rec_ready = first_seen;
  assign ilk_out   = ~trip;
  assign dac_out   = trip ? '0 : dac_in;

  always_comb begin
    rec_time  = '0;
    rec_value = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (rec_sel == SEL_W'(i)) begin
        rec_time  = rec_time_a[i];
        rec_value = rec_value_a[i];
      end
    end
  end
endmodule

module ilk_aggregator_chk #(
  parameter int N_SRC = 18,
  parameter int TS_W  = 32,
  parameter int DAC_W = 14,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_fault,
  input logic [N_SRC-1:0] latched,
  input logic             clear_go,
  input logic             host_clear,
  input logic             trip,
  input logic             ilk_out,
  input logic [DAC_W-1:0] dac_out,
  input logic [TS_W-1:0]  ts_now,
  input logic             rec_ready,
  input logic [SEL_W-1:0] first_src
);
  // R3
  fault_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_fault) |=> trip);
  // R4
  dac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (dac_out == '0 && !ilk_out));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_go |=> ((latched & $past(latched)) == $past(latched)));
  // R7
  live_blocks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clear && (|src_fault)) |=> trip);
  // R8
  timebase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (ts_now == $past(ts_now) + 1'b1));
  // R9
  first_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_ready && !clear_go) |=> $stable(first_src));
  // R9
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready == trip);
endmodule

bind ilk_aggregator ilk_aggregator_chk #(
  .N_SRC(N_SRC), .TS_W(TS_W), .DAC_W(DAC_W), .SEL_W(SEL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .src_fault(src_fault), .latched(latched),
  .clear_go(clear_go), .host_clear(host_clear), .trip(trip), .ilk_out(ilk_out),
  .dac_out(dac_out), .ts_now(ts_now), .rec_ready(rec_ready), .first_src(first_src)
);

// File: tb/ilk_aggregator_tb.sv
module ilk_aggregator_tb_top;
  localparam int N_RF = 9, N_BB = 8, SW = 8, TW = 16, DW = 12;
  localparam int NS = N_RF + N_BB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_RF*SW-1:0] rf_sample = '0;
  logic [N_RF*SW-1:0] rf_thresh = '1;
  logic [N_BB-1:0] bb_fault = '0;
  logic ext_ok = 1'b1;
  logic host_clear = 1'b0;
  logic [DW-1:0] dac_in = '0;
  logic [4:0] rec_sel = '0;
  logic [DW-1:0] dac_out;
  logic trip, ilk_out, rec_ready;
  logic [NS-1:0] latched;
  logic [4:0] first_src;
  logic [TW-1:0] rec_time;
  logic [SW-1:0] rec_value;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ilk_aggregator #(.N_RF(N_RF), .N_BB(N_BB), .SAMP_W(SW), .TS_W(TW), .DAC_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rf_sample(rf_sample), .rf_thresh(rf_thresh),
    .bb_fault(bb_fault), .ext_ok(ext_ok), .host_clear(host_clear), .dac_in(dac_in),
    .rec_sel(rec_sel), .dac_out(dac_out), .trip(trip), .ilk_out(ilk_out),
    .rec_ready(rec_ready), .latched(latched), .first_src(first_src),
    .rec_time(rec_time), .rec_value(rec_value)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_rf(input int ch, input int s);
    rf_sample[ch*SW +: SW] = SW'(s);
  endtask

  task automatic clear_all();
    rf_sample = '0;
    bb_fault = '0;
    ext_ok = 1'b1;
    tick();
    host_clear = 1'b1;
    tick();
    host_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int thr_list [4] = '{0, 50, 127, 255};
    logic [TW-1:0] t_a;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    check(latched == 0, "R10 latched", latched, 0);
    check(!trip && ilk_out && !rec_ready, "R10 trip/ilk/ready", {trip, ilk_out, rec_ready}, 3'b010);

    // R1 sweep of channel 3
    rec_sel = 5'd3;
    for (int k = 0; k < 4; k++) begin
      rf_thresh[3*SW +: SW] = SW'(thr_list[k]);
      for (int s = -128; s < 128; s++) begin
        int m;
        bit exp_f;
        m = (s < 0) ? -s : s;
        exp_f = (m > thr_list[k]);
        set_rf(3, s);
        tick();
        check(trip == exp_f, "R1 sweep trip", trip, exp_f);
        if (exp_f) begin
          check(rec_value == SW'(m), "R5 rf value", rec_value, m);
          check(latched == NS'(1 << 3), "R2 rf index", latched, 1 << 3);
        end
        clear_all();
        check(!trip, "R7 clear idle", trip, 0);
      end
    end
    rf_thresh = '1;

    // R2 R5 baseband bits
    for (int j = 0; j < N_BB; j++) begin
      bb_fault[j] = 1'b1;
      rec_sel = 5'(N_RF + j);
      tick();
      check(latched == NS'(1 << (N_RF + j)), "R2 bb index", latched, 1 << (N_RF + j));
      check(rec_value == 1, "R5 bb value", rec_value, 1);
      clear_all();
    end

    // R2 R4 R7 external permit
    dac_in = 12'hABC;
    tick();
    check(dac_out == 12'hABC && ilk_out, "R4 pass", dac_out, 12'hABC);
    ext_ok = 1'b0;
    rec_sel = 5'd17;
    tick();
    check(latched == NS'(1 << 17), "R2 ext index", latched, 1 << 17);
    check(rec_value == 0, "R5 ext value", rec_value, 0);
    check(dac_out == 0, "R4 dac zero", dac_out, 0);
    check(!ilk_out, "R4 ilk low", ilk_out, 0);
    host_clear = 1'b1;
    tick();
    host_clear = 1'b0;
    check(trip && latched[17], "R7 clear ignored while live", trip, 1);
    ext_ok = 1'b1;
    tick();
    check(trip, "R3 stays latched", trip, 1);
    host_clear = 1'b1;
    tick();
    host_clear = 1'b0;
    check(!trip && dac_out == 12'hABC, "R7 clear after release", trip, 0);

    // R6 first fault only
    rf_thresh[0 +: SW] = 8'd10;
    rec_sel = 5'd0;
    set_rf(0, 100);
    tick();
    t_a = rec_time;
    check(rec_value == 100, "R6 first value", rec_value, 100);
    set_rf(0, 120);
    repeat (4) tick();
    check(rec_value == 100, "R6 value held", rec_value, 100);
    check(rec_time == t_a, "R6 time held", rec_time, t_a);
    clear_all();

    // R8 R9 ordering
    rf_thresh = '0;
    set_rf(5, 1);
    tick();
    rec_sel = 5'd5;
    #1 t_a = rec_time;
    repeat (5) tick();
    set_rf(1, 1);
    tick();
    rec_sel = 5'd1;
    #1;
    check(rec_time - t_a == 6, "R8 time difference", rec_time - t_a, 6);
    check(first_src == 5, "R9 earliest", first_src, 5);
    check(rec_ready, "R9 ready", rec_ready, 1);
    clear_all();
    set_rf(7, 3);
    set_rf(2, -3);
    tick();
    check(first_src == 2, "R9 tie lowest", first_src, 2);
    clear_all();
    check(!rec_ready, "R9 ready cleared", rec_ready, 0);

    // R1 most negative sample
    rf_thresh = '1;
    rf_thresh[4*SW +: SW] = 8'd127;
    rec_sel = 5'd4;
    set_rf(4, -128);
    tick();
    check(trip && rec_value == 128, "R1 most negative", rec_value, 128);
    clear_all();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule